// File: doc/BRIEF.md
# Data Access Permission and Translation Checker

This block takes one data load or store per cycle and decides what happens to it. It checks whether the access-space code (ASI) may be used at the current privilege level, applies the alignment rule that goes with the ASI, rejects virtual addresses that fall in the unimplemented hole, and lets hypervisor accesses bypass translation. It selects the context and real/virtual mode for a lookup in an external translation buffer. It then checks the returned page for write permission, no-fault marking and privilege. The result is registered and appears one cycle after the request. The result is a fault code, or a physical address with an uncacheable flag, or an unsupported-ASI indication.

Faults are reported in a fixed priority order, and only the first fault found is reported. Every logged fault updates a sticky data fault status word and a fault address word. A lookup miss is reported but leaves both words untouched, so that miss handling software does not clobber the record of an earlier fault. ASI classes that need little-endian, paired, partial-store or MMU-register handling are not translated.

Top module: `data_access_checker`

## Requirements
- R1: While reset is held and after its release, `rsp_valid`, `fsr` and `far` are zero until the first request completes.
- R2: A request accepted with `req_valid` produces exactly one response with `rsp_valid` high in the next cycle. The fault code is 0 none, 1 privileged action, 2 data access exception, 3 misaligned, 4 miss, 5 real miss, 6 write protection. A response with a non-zero fault code carries `rsp_pa` = 0 and `rsp_uncached` = 0.
- R3: ASI fields are: bit 0 secondary, bit 1 no-fault, bit 2 real, bit 3 as-if-user, bits 6:4 class (0 privileged, 1 user, 2 hypervisor-only, 3 block, 4 to 7 unsupported). The context type is nucleus (lookup context 0) when `st_tl_nz` is set. Otherwise it is secondary (`ctx_secondary`) for an explicit ASI with the secondary bit set. Otherwise it is primary (`ctx_primary`).
- R4: When the ASI is explicit and the core is not in hypervisor mode, two cases fault. A non-privileged access with a class other than user raises fault 1. A privileged access with the hypervisor-only class raises fault 2. Both log fault type 1 (illegal ASI) with context type nucleus.
- R5: An explicit block-class access needs VA bits 5:0 clear. Every other access needs VA bits 2:0 clear. A violation raises fault 3 with fault type 2.
- R6: A VA whose bits 63:47 are not all equal raises fault 2 with fault type 3. This check comes after the alignment check.
- R7: An explicit ASI of class 4 to 7 that passes R4 to R6 sets `rsp_unsupported`. It raises no fault, does no lookup, and leaves `fsr` and `far` unchanged.
- R8: A lookup is real, with context 0, when the ASI is explicit with the real bit set, or when `mmu_en` is low outside hypervisor mode. A miss raises fault 5 for a real lookup and fault 4 otherwise.
- R9: In hypervisor mode, an implicit access, or an explicit ASI with neither the as-if-user bit nor the real bit, skips the lookup. It returns VA bits 39:0 as the physical address.
- R10: A store that hits a page without write permission raises fault 6 with fault type 2.
- R11: A hit on a no-fault page raises fault 2 with fault type 4, unless the ASI is explicit and has its no-fault bit set.
- R12: A non-privileged hit on a privileged page raises fault 2 with fault type 5.
- R13: A successful hit returns {page number, VA bits 12:0}. It sets `rsp_uncached` when the page has side effects. The page's side-effect bit is logged in `fsr` bit 5 on faults 2 and 6 raised by the page checks.
- R14: Faults 1, 2, 3 and 6 write `far` with the VA and write `fsr` as {ASI[16:9], fault type[8:6], side[5], context type[4:3], write[2], overwrite[1], valid[0]}. The overwrite bit copies the valid bit held before the write. Faults 4 and 5 leave both words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | VA_W | Virtual address |
| req_implicit | input | 1 | Access uses the implicit ASI |
| req_asi | input | 8 | Explicit ASI code |
| req_write | input | 1 | Access is a store |
| st_priv | input | 1 | Privileged mode |
| st_hyper | input | 1 | Hypervisor or recovery mode |
| st_tl_nz | input | 1 | Trap level above zero |
| mmu_en | input | 1 | Data translation enabled |
| ctx_primary | input | CTX_W | Primary context |
| ctx_secondary | input | CTX_W | Secondary context |
| lk_req | output | 1 | Lookup needed for the current request |
| lk_va | output | VA_W | Lookup virtual address |
| lk_ctx | output | CTX_W | Lookup context |
| lk_real | output | 1 | Lookup is real |
| lk_hit | input | 1 | Lookup hit |
| lk_ppn | input | PA_W-PAGE_BITS | Physical page number |
| lk_writable | input | 1 | Page is writable |
| lk_nofault | input | 1 | Page is no-fault only |
| lk_side_effect | input | 1 | Page has side effects |
| lk_priv | input | 1 | Page is privileged |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 3 | Fault code |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncached | output | 1 | Access must bypass caches |
| rsp_unsupported | output | 1 | ASI class not handled |
| fsr | output | 17 | Data fault status |
| far | output | VA_W | Fault address |

## Verification
The bench concentrates on the priority boundaries. These cases include a block access that is 8-byte but not 64-byte aligned, addresses just inside and just outside the VA hole, and a hypervisor access through a real ASI that must still reach the lookup. A design that tests the hole before alignment, or that mixes up the two alignment rules, reports the wrong fault code. A bypass that forgets the as-if-user or real exception skips the lookup and returns the raw VA. The bench also covers a no-fault page reached through a no-fault ASI, which must not fault. It covers a miss after a logged fault, which must leave the status word alone, and two faults in a row, which must set the overwrite bit. A wrong context or real selection shows up at once in the lookup port and in the physical address, because the modelled buffer mixes both into the page number.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int ASI_W = 8;
  localparam int FSR_W = 17;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_PRIV_ACT  = 3'd1,
    FLT_DATA_EXC  = 3'd2,
    FLT_MISALIGN  = 3'd3,
    FLT_MISS      = 3'd4,
    FLT_REAL_MISS = 3'd5,
    FLT_PROT      = 3'd6
  } fault_e;

  typedef enum logic [2:0] {
    FT_NONE      = 3'd0,
    FT_ILL_ASI   = 3'd1,
    FT_OTHER     = 3'd2,
    FT_VA_RANGE  = 3'd3,
    FT_NFO_LOAD  = 3'd4,
    FT_PRIV_VIOL = 3'd5
  } ftype_e;

  typedef enum logic [1:0] {
    CT_PRI = 2'd0,
    CT_SEC = 2'd1,
    CT_NUC = 2'd2
  } ctype_e;

  localparam logic [2:0] CLS_PRIV  = 3'd0;
  localparam logic [2:0] CLS_USER  = 3'd1;
  localparam logic [2:0] CLS_HYP   = 3'd2;
  localparam logic [2:0] CLS_BLOCK = 3'd3;

  typedef struct packed {
    logic [ASI_W-1:0] asi;
    ftype_e           ft;
    logic             side;
    ctype_e           ct;
    logic             wr;
    logic             ovw;
    logic             vld;
  } fsr_t;
endpackage

// File: rtl/dac_ctx_sel.sv
module dac_ctx_sel
  import dac_pkg::*;
#(
  parameter int CTX_W = 13
) (
  input  logic             implicit_i,
  input  logic             asi_sec_i,
  input  logic             asi_real_i,
  input  logic             asi_asif_user_i,
  input  logic             tl_nz_i,
  input  logic             hyper_i,
  input  logic             mmu_en_i,
  input  logic [CTX_W-1:0] pctx_i,
  input  logic [CTX_W-1:0] sctx_i,
  output ctype_e           ct_o,
  output logic [CTX_W-1:0] ctx_o,
  output logic             real_o,
  output logic             bypass_o
);
  logic [CTX_W-1:0] sel_ctx;

  always_comb begin
    if (tl_nz_i)                      ct_o = CT_NUC;
    else if (!implicit_i && asi_sec_i) ct_o = CT_SEC;
    else                              ct_o = CT_PRI;

    unique case (ct_o)
      CT_SEC:  sel_ctx = sctx_i;
      CT_PRI:  sel_ctx = pctx_i;
      default: sel_ctx = '0;
    endcase

    real_o   = (!implicit_i && asi_real_i) || (!mmu_en_i && !hyper_i);
    ctx_o    = real_o ? '0 : sel_ctx;
    bypass_o = hyper_i && (implicit_i || (!asi_asif_user_i && !asi_real_i));
  end
endmodule

// File: rtl/dac_front.sv
module dac_front
  import dac_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int HOLE_BIT = 47
) (
  input  logic                   implicit_i,
  input  logic [2:0]             cls_i,
  input  logic                   priv_i,
  input  logic                   hyper_i,
  input  logic [5:0]             va_lo_i,
  input  logic [VA_W-1:HOLE_BIT] va_hi_i,
  output fault_e                 code_o,
  output ftype_e                 ft_o,
  output logic                   nuc_o,
  output logic                   unsup_o
);
  logic explicit_chk, blk, misal, hole;

  always_comb begin
    explicit_chk = !implicit_i && !hyper_i;
    blk          = !implicit_i && (cls_i == CLS_BLOCK);
    misal        = blk ? (|va_lo_i) : (|va_lo_i[2:0]);
    hole         = !((&va_hi_i) || !(|va_hi_i));

    code_o  = FLT_NONE;
    ft_o    = FT_NONE;
    nuc_o   = 1'b0;
    unsup_o = 1'b0;
    if (explicit_chk && !priv_i && cls_i != CLS_USER) begin
      code_o = FLT_PRIV_ACT;
      ft_o   = FT_ILL_ASI;
      nuc_o  = 1'b1;
    end else if (explicit_chk && priv_i && cls_i == CLS_HYP) begin
      code_o = FLT_DATA_EXC;
      ft_o   = FT_ILL_ASI;
      nuc_o  = 1'b1;
    end else if (misal) begin
      code_o = FLT_MISALIGN;
      ft_o   = FT_OTHER;
    end else if (hole) begin
      code_o = FLT_DATA_EXC;
      ft_o   = FT_VA_RANGE;
    end else begin
      unsup_o = !implicit_i && cls_i[2];
    end
  end
endmodule

// File: rtl/dac_prot.sv
module dac_prot
  import dac_pkg::*;
(
  input  logic   write_i,
  input  logic   priv_i,
  input  logic   nf_asi_i,
  input  logic   real_i,
  input  logic   hit_i,
  input  logic   writable_i,
  input  logic   nofault_i,
  input  logic   page_priv_i,
  output fault_e code_o,
  output ftype_e ft_o
);
  always_comb begin
    code_o = FLT_NONE;
    ft_o   = FT_NONE;
    if (!hit_i) begin
      code_o = real_i ? FLT_REAL_MISS : FLT_MISS;
    end else if (write_i && !writable_i) begin
      code_o = FLT_PROT;
      ft_o   = FT_OTHER;
    end else if (nofault_i && !nf_asi_i) begin
      code_o = FLT_DATA_EXC;
      ft_o   = FT_NFO_LOAD;
    end else if (!priv_i && page_priv_i) begin
      code_o = FLT_DATA_EXC;
      ft_o   = FT_PRIV_VIOL;
    end
  end
endmodule

// File: rtl/data_access_checker.sv
module data_access_checker
  import dac_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 13,
  parameter int CTX_W     = 13,
  parameter int HOLE_BIT  = 47
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_va,
  input  logic                      req_implicit,
  input  logic [7:0]                req_asi,
  input  logic                      req_write,
  input  logic                      st_priv,
  input  logic                      st_hyper,
  input  logic                      st_tl_nz,
  input  logic                      mmu_en,
  input  logic [CTX_W-1:0]          ctx_primary,
  input  logic [CTX_W-1:0]          ctx_secondary,
  output logic                      lk_req,
  output logic [VA_W-1:0]           lk_va,
  output logic [CTX_W-1:0]          lk_ctx,
  output logic                      lk_real,
  input  logic                      lk_hit,
  input  logic [PA_W-PAGE_BITS-1:0] lk_ppn,
  input  logic                      lk_writable,
  input  logic                      lk_nofault,
  input  logic                      lk_side_effect,
  input  logic                      lk_priv,
  output logic                      rsp_valid,
  output logic [2:0]                rsp_fault,
  output logic [PA_W-1:0]           rsp_pa,
  output logic                      rsp_uncached,
  output logic                      rsp_unsupported,
  output logic [16:0]               fsr,
  output logic [VA_W-1:0]           far
);
  ctype_e ct_sel;
  logic   real_w, byp_w, f_nuc, unsup_w;
  fault_e f_code, p_code;
  ftype_e f_ft, p_ft;

  dac_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
    .implicit_i(req_implicit), .asi_sec_i(req_asi[0]), .asi_real_i(req_asi[2]),
    .asi_asif_user_i(req_asi[3]), .tl_nz_i(st_tl_nz), .hyper_i(st_hyper),
    .mmu_en_i(mmu_en), .pctx_i(ctx_primary), .sctx_i(ctx_secondary),
    .ct_o(ct_sel), .ctx_o(lk_ctx), .real_o(real_w), .bypass_o(byp_w)
  );

  dac_front #(.VA_W(VA_W), .HOLE_BIT(HOLE_BIT)) u_front (
    .implicit_i(req_implicit), .cls_i(req_asi[6:4]), .priv_i(st_priv),
    .hyper_i(st_hyper), .va_lo_i(req_va[5:0]), .va_hi_i(req_va[VA_W-1:HOLE_BIT]),
    .code_o(f_code), .ft_o(f_ft), .nuc_o(f_nuc), .unsup_o(unsup_w)
  );

  dac_prot u_prot (
    .write_i(req_write), .priv_i(st_priv), .nf_asi_i(!req_implicit && req_asi[1]),
    .real_i(real_w), .hit_i(lk_hit), .writable_i(lk_writable),
    .nofault_i(lk_nofault), .page_priv_i(lk_priv), .code_o(p_code), .ft_o(p_ft)
  );

  // next-state signals
  fault_e         code_n;
  ftype_e         ft_n;
  ctype_e         ct_n;
  logic           side_n, unc_n, uns_n, log_n, fsr_we;
  logic [PA_W-1:0] pa_n;
  fsr_t           fsr_q, fsr_n;
  logic [VA_W-1:0] far_q;
  logic           rsp_valid_q, unc_q, uns_q;
  fault_e         code_q;
  logic [PA_W-1:0] pa_q;

  assign lk_real = real_w;
  assign lk_va   = req_va;
  assign lk_req  = req_valid && (f_code == FLT_NONE) && !unsup_w && !byp_w;

  always_comb begin
    code_n = FLT_NONE;
    ft_n   = FT_NONE;
    ct_n   = ct_sel;
    side_n = 1'b0;
    unc_n  = 1'b0;
    uns_n  = 1'b0;
    pa_n   = '0;
    if (f_code != FLT_NONE) begin
      code_n = f_code;
      ft_n   = f_ft;
      if (f_nuc) ct_n = CT_NUC;
    end else if (unsup_w) begin
      uns_n = 1'b1;
    end else if (byp_w) begin
      pa_n = req_va[PA_W-1:0];
    end else begin
      code_n = p_code;
      ft_n   = p_ft;
      side_n = lk_hit && lk_side_effect;
      if (p_code == FLT_NONE) begin
        pa_n  = {lk_ppn, req_va[PAGE_BITS-1:0]};
        unc_n = lk_side_effect;
      end
    end
    log_n  = (code_n == FLT_PRIV_ACT) || (code_n == FLT_DATA_EXC) ||
             (code_n == FLT_MISALIGN) || (code_n == FLT_PROT);
    fsr_we = req_valid && log_n;
    fsr_n  = '{asi: req_asi, ft: ft_n, side: side_n, ct: ct_n,
               wr: req_write, ovw: fsr_q.vld, vld: 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      code_q      <= FLT_NONE;
      pa_q        <= '0;
      unc_q       <= 1'b0;
      uns_q       <= 1'b0;
      fsr_q       <= '0;
      far_q       <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      if (req_valid) begin
        code_q <= code_n;
        pa_q   <= pa_n;
        unc_q  <= unc_n;
        uns_q  <= uns_n;
      end
      if (fsr_we) begin
        fsr_q <= fsr_n;
        far_q <= req_va;
      end
    end
  end

  assign rsp_valid       = rsp_valid_q;
  assign rsp_fault       = code_q;
  assign rsp_pa          = pa_q;
  assign rsp_uncached    = unc_q;
  assign rsp_unsupported = uns_q;
  assign fsr             = fsr_q;
  assign far             = far_q;
endmodule

// File: rtl/data_access_checker_sva.sv
module data_access_checker_sva #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 40,
  parameter int CTX_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_va,
  input logic             lk_req,
  input logic [CTX_W-1:0] lk_ctx,
  input logic             lk_real,
  input logic             rsp_valid,
  input logic [2:0]       rsp_fault,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             rsp_uncached,
  input logic             rsp_unsupported,
  input logic [16:0]      fsr,
  input logic [VA_W-1:0]  far
);
  AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R2
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncached)); // R2
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unsupported) |-> (rsp_fault == 3'd0 && $stable(fsr) && $stable(far))); // R7
  AST_REAL_CTX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_real) |-> lk_ctx == '0); // R8
  AST_FAR_ON_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault == 3'd1 || rsp_fault == 3'd2 || rsp_fault == 3'd3 || rsp_fault == 3'd6))
    |-> (far == $past(req_va) && fsr[0])); // R14
  AST_MISS_KEEPS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5)) |-> ($stable(fsr) && $stable(far))); // R14
  AST_FSR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fsr[0] |=> fsr[0]); // R14
endmodule

bind data_access_checker data_access_checker_sva #(
  .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)
) u_sva (.*);

// File: tb/tb_data_access_checker.sv
`timescale 1ns/1ps
module tb_data_access_checker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_implicit, req_write, st_priv, st_hyper, st_tl_nz, mmu_en;
  logic [63:0] req_va;
  logic [7:0]  req_asi;
  logic [12:0] ctx_primary, ctx_secondary;
  logic        lk_req, lk_real, lk_hit, lk_writable, lk_nofault, lk_side_effect, lk_priv;
  logic [63:0] lk_va;
  logic [12:0] lk_ctx;
  logic [26:0] lk_ppn;
  logic        rsp_valid, rsp_uncached, rsp_unsupported;
  logic [2:0]  rsp_fault;
  logic [39:0] rsp_pa;
  logic [16:0] fsr;
  logic [63:0] far;

  data_access_checker dut (.*);

  // external translation buffer model: miss when VA[15:13]==7, attributes from VA[22:16]
  function automatic logic [31:0] tlb_fn(input logic [63:0] va, input logic [12:0] c, input logic r);
    logic hit, w, nf, se, pp;
    logic [26:0] ppn;
    hit = !(&va[15:13]);
    w   = va[16] | va[17];
    nf  = va[18] & va[19];
    se  = va[20];
    pp  = va[21] & va[22];
    ppn = va[39:13] ^ {14'd0, c} ^ {26'd0, r};
    return {hit, w, nf, se, pp, ppn};
  endfunction

  always_comb {lk_hit, lk_writable, lk_nofault, lk_side_effect, lk_priv, lk_ppn} = tlb_fn(lk_va, lk_ctx, lk_real);

  int n_chk = 0, n_bad = 0;
  logic [16:0] m_fsr;
  logic [63:0] m_far;
  logic [2:0]  e_f;
  logic [39:0] e_pa;
  logic        e_unc, e_uns, e_lkr, e_real, e_log;
  logic [12:0] e_ctx;
  logic [16:0] e_fsr;
  string       tag;

  task automatic chk(input bit ok, input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  task automatic predict();
    logic [2:0] cls, ft;
    logic [1:0] ct;
    logic [12:0] selc;
    logic byp, side, hit, w, nf, se, pp;
    logic [26:0] ppn;
    cls  = req_asi[6:4];
    ct   = st_tl_nz ? 2'd2 : (!req_implicit && req_asi[0]) ? 2'd1 : 2'd0;
    selc = (ct == 2'd2) ? 13'd0 : (ct == 2'd1) ? ctx_secondary : ctx_primary;
    e_real = (!req_implicit && req_asi[2]) || (!mmu_en && !st_hyper);
    e_ctx  = e_real ? 13'd0 : selc;
    byp  = st_hyper && (req_implicit || (!req_asi[3] && !req_asi[2]));
    e_f = 3'd0; ft = 3'd0; side = 1'b0; e_pa = '0; e_unc = 1'b0; e_uns = 1'b0; e_lkr = 1'b0;
    tag = "R3";
    if (!req_implicit && !st_hyper && !st_priv && cls != 3'd1) begin
      e_f = 3'd1; ft = 3'd1; ct = 2'd2; tag = "R4";
    end else if (!req_implicit && !st_hyper && st_priv && cls == 3'd2) begin
      e_f = 3'd2; ft = 3'd1; ct = 2'd2; tag = "R4";
    end else if ((!req_implicit && cls == 3'd3) ? (req_va[5:0] != 0) : (req_va[2:0] != 0)) begin
      e_f = 3'd3; ft = 3'd2; tag = "R5";
    end else if (!((&req_va[63:47]) || !(|req_va[63:47]))) begin
      e_f = 3'd2; ft = 3'd3; tag = "R6";
    end else if (!req_implicit && cls[2]) begin
      e_uns = 1'b1; tag = "R7";
    end else if (byp) begin
      e_pa = req_va[39:0]; tag = "R9";
    end else begin
      e_lkr = 1'b1;
      {hit, w, nf, se, pp, ppn} = tlb_fn(req_va, e_ctx, e_real);
      if (!hit) begin
        e_f = e_real ? 3'd5 : 3'd4; tag = "R8";
      end else if (req_write && !w) begin
        e_f = 3'd6; ft = 3'd2; side = se; tag = "R10";
      end else if (nf && !(!req_implicit && req_asi[1])) begin
        e_f = 3'd2; ft = 3'd4; side = se; tag = "R11";
      end else if (!st_priv && pp) begin
        e_f = 3'd2; ft = 3'd5; side = se; tag = "R12";
      end else begin
        e_pa = {ppn, req_va[12:0]}; e_unc = se; tag = "R13";
      end
    end
    e_log = (e_f == 3'd1) || (e_f == 3'd2) || (e_f == 3'd3) || (e_f == 3'd6);
    e_fsr = {req_asi, ft, side, ct, req_write, m_fsr[0], 1'b1};
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic send(input logic [63:0] va, input logic imp, input logic [7:0] asi, input logic wr,
                      input logic pv, input logic hy, input logic tl, input logic en);
    req_va = va; req_implicit = imp; req_asi = asi; req_write = wr;
    st_priv = pv; st_hyper = hy; st_tl_nz = tl; mmu_en = en;
    ctx_primary = 13'($urandom); ctx_secondary = 13'($urandom);
    req_valid = 1'b1;
    predict();
    #1;
    chk(lk_req == e_lkr, e_lkr ? "R8" : tag, "lk_req", 64'(lk_req), 64'(e_lkr));
    if (e_lkr) begin
      chk(lk_ctx == e_ctx, "R3", "lk_ctx", 64'(lk_ctx), 64'(e_ctx));
      chk(lk_real == e_real, "R8", "lk_real", 64'(lk_real), 64'(e_real));
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (e_log) begin
      m_fsr = e_fsr; m_far = va;
    end
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_fault == e_f, tag, "fault", 64'(rsp_fault), 64'(e_f));
    chk(rsp_pa == e_pa, (e_f != 0) ? "R2" : tag, "pa", 64'(rsp_pa), 64'(e_pa));
    chk(rsp_uncached == e_unc, "R13", "uncached", 64'(rsp_uncached), 64'(e_unc));
    chk(rsp_unsupported == e_uns, "R7", "unsupported", 64'(rsp_unsupported), 64'(e_uns));
    chk(fsr == m_fsr, "R14", "fsr", 64'(fsr), 64'(m_fsr));
    chk(far == m_far, "R14", "far", far, m_far);
  endtask

  task automatic idle();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  function automatic logic [63:0] rand_va();
    logic [63:0] r;
    logic s;
    r = {$urandom, $urandom};
    s = r[63];
    if ($urandom_range(9) != 0) r = {{17{s}}, r[46:0]};
    if ($urandom_range(3) != 0) r[5:0] = 6'd0;
    else if ($urandom_range(1) != 0) r[2:0] = 3'd0;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_fsr = '0; m_far = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_implicit = 1'b0; req_asi = '0;
    req_write = 1'b0; st_priv = 1'b0; st_hyper = 1'b0; st_tl_nz = 1'b0; mmu_en = 1'b0;
    ctx_primary = '0; ctx_secondary = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && fsr == 0 && far == 0, "R1", "reset state", {fsr, 47'(rsp_valid)}, 64'd0);
    rst_n = 1'b1;
    idle();
    chk(fsr == 0 && far == 0, "R1", "after release", 64'(fsr) | far, 64'd0);

    // directed corner cases
    send(64'h0000_0001_0001_0000, 1, 8'h00, 0, 0, 0, 0, 1); // R13 plain hit
    send(64'h0000_0001_0000_0000, 1, 8'h00, 1, 0, 0, 0, 1); // R10 store to read-only
    send(64'h0000_0001_000D_0000, 1, 8'h00, 0, 0, 0, 0, 1); // R11 no-fault page, implicit
    send(64'h0000_0001_000D_0000, 0, 8'h12, 0, 0, 0, 0, 1); // R11 no-fault ASI: clean
    send(64'h0000_0001_0061_0000, 1, 8'h00, 0, 0, 0, 0, 1); // R12 privileged page, user
    send(64'h0000_0001_0011_0000, 1, 8'h00, 0, 1, 0, 0, 1); // R13 side effects
    send(64'h0000_0001_0010_0000, 1, 8'h00, 1, 1, 0, 0, 1); // R13 side bit logged on prot
    send(64'h0000_0000_0001_0000, 0, 8'h00, 0, 0, 0, 0, 1); // R4 privileged ASI from user
    send(64'h0000_0000_0001_0000, 0, 8'h20, 0, 1, 0, 0, 1); // R4 hyper-only ASI, R14 overwrite
    send(64'h0000_0000_0001_0008, 0, 8'h30, 0, 1, 0, 0, 1); // R5 block needs 64B
    send(64'h0000_0000_0001_0040, 0, 8'h30, 0, 1, 0, 0, 1); // R5 block aligned
    send(64'h0000_0000_0001_0004, 1, 8'h00, 0, 1, 0, 0, 1); // R5 8B rule
    send(64'h0000_7FFF_FFFF_FFF8, 1, 8'h00, 0, 1, 0, 0, 1); // R6 top of low half
    send(64'h0000_8000_0000_0000, 1, 8'h00, 0, 1, 0, 0, 1); // R6 hole start
    send(64'hFFFF_8000_0000_0000, 1, 8'h00, 0, 1, 0, 0, 1); // R6 bottom of high half
    send(64'h0000_8000_0000_0004, 1, 8'h00, 0, 1, 0, 0, 1); // R5 before R6
    send(64'h0000_0000_0001_0000, 0, 8'h40, 0, 1, 0, 0, 1); // R7 unsupported class
    send(64'h0000_0000_0001_0000, 0, 8'h70, 0, 1, 0, 0, 1); // R7 unsupported class
    send(64'h0000_00AB_CDEF_0000, 1, 8'h00, 0, 1, 1, 0, 1); // R9 hyper implicit bypass
    send(64'h0000_00AB_CDEF_0000, 0, 8'h04, 0, 1, 1, 0, 1); // R8 hyper real ASI looks up
    send(64'h0000_00AB_CDEF_0000, 0, 8'h08, 0, 1, 1, 0, 1); // R9 as-if-user not bypassed
    send(64'h0000_0000_0001_E000, 1, 8'h00, 0, 1, 0, 0, 0); // R8 mmu off real miss
    send(64'h0000_0000_0001_E000, 1, 8'h00, 0, 1, 0, 0, 1); // R8 virtual miss
    send(64'h0000_0000_0001_0000, 0, 8'h11, 0, 0, 0, 0, 1); // R3 secondary
    send(64'h0000_0000_0001_0000, 0, 8'h11, 0, 0, 0, 1, 1); // R3 nucleus
    idle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] asi;
      asi = 8'($urandom);
      if ($urandom_range(2) != 0) asi[6:4] = 3'($urandom_range(3));
      send(rand_va(), ($urandom_range(4) < 2), asi, 1'($urandom), ($urandom_range(3) != 0),
           ($urandom_range(4) == 0), ($urandom_range(9) < 3), ($urandom_range(3) != 0));
      if ($urandom_range(5) == 0) idle();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule